// File: doc/BRIEF.md
# Serial Codec Link Receive Deframer

This block takes the serial data line coming back from an audio codec on a sync-framed serial link and turns it into parallel slots. It runs entirely on the codec's bit clock (12.288 MHz nominal) and samples the data line and the frame sync line on the falling edge of that clock, because the codec launches both on the rising edge. A frame is 256 bit times, which gives 48 kHz. The frame starts with a 16-bit tag slot and carries twelve 20-bit data slots after it, most significant bit first.

Each frame starts at a low-to-high transition of the sync line. The bit present on that same sampling edge is the first bit of the tag slot. When the last bit of a frame has been captured, the block loads all slots into output registers in one step and raises a one-bit-time strobe. It also gives the codec-ready flag, a per-slot valid vector decoded from the tag, and the 18-bit left-justified sample from every data slot. These outputs hold their values until the next complete frame. If a new sync edge cuts a frame short, the partial frame is dropped, a framing-error pulse is raised, and capture restarts at that edge.

Top module: `aclink_rx_deframer`

## Requirements
- R1: A synchronous active-high reset, sampled on a falling bit-clock edge, clears every output to zero. After reset, no frame is captured until the sync line has been seen low and then high. A sync line that stays high through reset and after it does not start a frame.
- R2: Inputs are sampled on the falling bit-clock edge. The data bit sampled on the edge where sync is first seen high is bit 15 (the MSB) of the tag slot.
- R3: A frame is 256 bits sent MSB first: the 16-bit tag slot, then data slots 1 to 12, each 20 bits. Data slot n appears on `slot_data[(n-1)*20 +: 20]`.
- R4: `frame_valid` is high for exactly one bit-clock period. It rises on the falling edge that captures the 256th bit of a frame, and the slot outputs update on that same edge.
- R5: `tag_slot`, `slot_data`, `pcm_data`, `codec_ready` and `slot_valid` keep their values until the next frame completes.
- R6: `codec_ready` equals bit 15 of the last completed tag slot.
- R7: `slot_valid[n-1]` equals tag bit 15-n, for n = 1 to 12. A tag of 0xF800 gives `slot_valid` = 0x00F (slots 1 to 4), 0x9800 gives 0x00C (slots 3 and 4), and 0xFFF8 gives 0xFFF.
- R8: `pcm_data[(n-1)*18 +: 18]` equals bits 19:2 of data slot n. The two LSBs are padding and are dropped.
- R9: A sync rising edge that arrives after between 1 and 255 bits of a frame have been captured gives a one-period `frame_err` pulse on the next edge. The partial frame produces no `frame_valid`, and a new frame starts on that edge.
- R10: Once a frame has completed, further data bits are ignored until the next sync rising edge. They give no `frame_valid` and leave the outputs unchanged. A sync edge on the very next bit after a complete frame is not an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ac_bclk | input | 1 | Codec bit clock; all logic uses its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| ac_sync | input | 1 | Frame sync from the link; a rising edge starts a frame |
| ac_sdin | input | 1 | Serial data from the codec, MSB first |
| frame_valid | output | 1 | One-period strobe when a full frame has been loaded |
| frame_err | output | 1 | One-period pulse when a frame is cut short by sync |
| codec_ready | output | 1 | Codec-ready flag from the last tag slot |
| slot_valid | output | 12 | Per-data-slot valid tags; bit n-1 is slot n |
| tag_slot | output | 16 | Last completed tag slot |
| slot_data | output | 240 | Data slots 1 to 12, slot n at bits (n-1)*20 and up |
| pcm_data | output | 216 | 18-bit samples of slots 1 to 12, slot n at bits (n-1)*18 and up |

## Verification
All results are registered on falling bit-clock edges. The slot outputs and `frame_valid` change on the edge that samples the 256th bit, and `frame_err` rises one falling edge after the sync edge that interrupts a frame. The bench changes the inputs on rising edges and reads outputs on the rising edge that follows the edge of interest, which is half a bit time after that falling edge. A monitor counts the strobe and error pulses on every rising edge, so each one-period pulse is counted exactly once. Pulse-count deltas are compared only after idle bits have let every pending pulse settle.

// File: rtl/aclrx_pkg.sv
`timescale 1ns/1ps
package aclrx_pkg;
  localparam int TAG_W_D    = 16;
  localparam int SLOT_W_D   = 20;
  localparam int NSLOT_D    = 12;
  localparam int SAMPLE_W_D = 18;
endpackage

// File: rtl/aclrx_sync_edge.sv
`timescale 1ns/1ps
module aclrx_sync_edge (
  input  logic clk_n,
  input  logic rst,
  input  logic sync_i,
  output logic start_o
);
  logic sync_q;

  // Held high in reset so that a sync line already high does not count as an edge.
  always_ff @(negedge clk_n) begin
    if (rst) sync_q <= 1'b1;
    else     sync_q <= sync_i;
  end

  assign start_o = sync_i & ~sync_q;
endmodule

// File: rtl/aclrx_bitpos.sv
`timescale 1ns/1ps
module aclrx_bitpos #(
  parameter int FRAME_BITS = 256
) (
  input  logic clk_n,
  input  logic rst,
  input  logic start_i,
  output logic capture_o,
  output logic last_o,
  output logic ferr_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] cnt_q;   // bits captured in the current frame, 0 when idle
  logic             busy;

  assign busy      = (cnt_q != '0);
  assign capture_o = start_i | busy;
  assign last_o    = ~start_i & (cnt_q == LAST_POS);

  always_ff @(negedge clk_n) begin
    if (rst) begin
      cnt_q  <= '0;
      ferr_o <= 1'b0;
    end else begin
      ferr_o <= start_i & busy;
      if (start_i)     cnt_q <= CNT_W'(1);
      else if (last_o) cnt_q <= '0;
      else if (busy)   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/aclrx_shift.sv
`timescale 1ns/1ps
module aclrx_shift #(
  parameter int W = 256
) (
  input  logic         clk_n,
  input  logic         rst,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q;

  assign word_o = {sh_q[W-2:0], din_i};

  always_ff @(negedge clk_n) begin
    if (rst)       sh_q <= '0;
    else if (en_i) sh_q <= word_o;
  end
endmodule

// File: rtl/aclrx_unpack.sv
`timescale 1ns/1ps
module aclrx_unpack #(
  parameter int TAG_W    = 16,
  parameter int SLOT_W   = 20,
  parameter int NSLOT    = 12,
  parameter int SAMPLE_W = 18
) (
  input  logic                      clk_n,
  input  logic                      rst,
  input  logic                      load_i,
  input  logic [TAG_W+NSLOT*SLOT_W-1:0] frame_i,
  output logic                      fv_o,
  output logic                      ready_o,
  output logic [NSLOT-1:0]          valid_o,
  output logic [TAG_W-1:0]          tag_o,
  output logic [NSLOT*SLOT_W-1:0]   slots_o,
  output logic [NSLOT*SAMPLE_W-1:0] pcm_o
);
  localparam int W = TAG_W + NSLOT * SLOT_W;

  always_ff @(negedge clk_n) begin
    if (rst) begin
      fv_o    <= 1'b0;
      ready_o <= 1'b0;
      tag_o   <= '0;
    end else begin
      fv_o <= load_i;
      if (load_i) begin
        ready_o <= frame_i[W-1];
        tag_o   <= frame_i[W-1 -: TAG_W];
      end
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam int TOP = W - TAG_W - i * SLOT_W - 1;

    always_ff @(negedge clk_n) begin
      if (rst) begin
        valid_o[i]                      <= 1'b0;
        slots_o[i*SLOT_W +: SLOT_W]     <= '0;
        pcm_o[i*SAMPLE_W +: SAMPLE_W]   <= '0;
      end else if (load_i) begin
        valid_o[i]                      <= frame_i[W-2-i];
        slots_o[i*SLOT_W +: SLOT_W]     <= frame_i[TOP -: SLOT_W];
        pcm_o[i*SAMPLE_W +: SAMPLE_W]   <= frame_i[TOP -: SAMPLE_W];
      end
    end
  end
endmodule

// File: rtl/aclink_rx_deframer.sv
`timescale 1ns/1ps
module aclink_rx_deframer #(
  parameter int TAG_W    = aclrx_pkg::TAG_W_D,
  parameter int SLOT_W   = aclrx_pkg::SLOT_W_D,
  parameter int NSLOT    = aclrx_pkg::NSLOT_D,
  parameter int SAMPLE_W = aclrx_pkg::SAMPLE_W_D
) (
  input  logic                      ac_bclk,
  input  logic                      rst,
  input  logic                      ac_sync,
  input  logic                      ac_sdin,
  output logic                      frame_valid,
  output logic                      frame_err,
  output logic                      codec_ready,
  output logic [NSLOT-1:0]          slot_valid,
  output logic [TAG_W-1:0]          tag_slot,
  output logic [NSLOT*SLOT_W-1:0]   slot_data,
  output logic [NSLOT*SAMPLE_W-1:0] pcm_data
);
  localparam int FRAME_BITS = TAG_W + NSLOT * SLOT_W;

  logic                  start;
  logic                  capture;
  logic                  last_bit;
  logic [FRAME_BITS-1:0] word;

  aclrx_sync_edge u_edge (
    .clk_n   (ac_bclk),
    .rst     (rst),
    .sync_i  (ac_sync),
    .start_o (start)
  );

  aclrx_bitpos #(.FRAME_BITS(FRAME_BITS)) u_pos (
    .clk_n     (ac_bclk),
    .rst       (rst),
    .start_i   (start),
    .capture_o (capture),
    .last_o    (last_bit),
    .ferr_o    (frame_err)
  );

  aclrx_shift #(.W(FRAME_BITS)) u_shift (
    .clk_n  (ac_bclk),
    .rst    (rst),
    .en_i   (capture),
    .din_i  (ac_sdin),
    .word_o (word)
  );

  aclrx_unpack #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NSLOT(NSLOT), .SAMPLE_W(SAMPLE_W)
  ) u_unpack (
    .clk_n   (ac_bclk),
    .rst     (rst),
    .load_i  (last_bit),
    .frame_i (word),
    .fv_o    (frame_valid),
    .ready_o (codec_ready),
    .valid_o (slot_valid),
    .tag_o   (tag_slot),
    .slots_o (slot_data),
    .pcm_o   (pcm_data)
  );
endmodule

// File: rtl/aclink_rx_deframer_chk.sv
`timescale 1ns/1ps
module aclink_rx_deframer_chk #(
  parameter int FRAME_BITS = 256,
  parameter int TAG_W      = 16,
  parameter int DATA_W     = 240
) (
  input logic              ac_bclk,
  input logic              rst,
  input logic              frame_valid,
  input logic              frame_err,
  input logic [TAG_W-1:0]  tag_slot,
  input logic [DATA_W-1:0] slot_data
);
  localparam int GW = $clog2(FRAME_BITS + 2);
  localparam logic [GW-1:0] GMAX = GW'(FRAME_BITS);

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(negedge ac_bclk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (frame_valid) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != GMAX) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  a_r4_single_strobe: assert property (@(negedge ac_bclk) disable iff (rst)
    frame_valid |=> !frame_valid);

  a_r4_strobe_spacing: assert property (@(negedge ac_bclk) disable iff (rst)
    (frame_valid && seen_q) |-> (gap_q >= GW'(FRAME_BITS - 1)));

  a_r5_tag_hold: assert property (@(negedge ac_bclk) disable iff (rst)
    (!$past(rst) && !$stable(tag_slot)) |-> frame_valid);

  a_r5_data_hold: assert property (@(negedge ac_bclk) disable iff (rst)
    (!$past(rst) && !$stable(slot_data)) |-> frame_valid);

  a_r9_err_single: assert property (@(negedge ac_bclk) disable iff (rst)
    frame_err |=> !frame_err);

  a_r9_err_no_strobe: assert property (@(negedge ac_bclk) disable iff (rst)
    frame_err |-> !frame_valid);
endmodule

bind aclink_rx_deframer aclink_rx_deframer_chk #(
  .FRAME_BITS(FRAME_BITS), .TAG_W(TAG_W), .DATA_W(NSLOT*SLOT_W)
) u_chk (
  .ac_bclk     (ac_bclk),
  .rst         (rst),
  .frame_valid (frame_valid),
  .frame_err   (frame_err),
  .tag_slot    (tag_slot),
  .slot_data   (slot_data)
);

// File: tb/aclink_rx_deframer_tb.sv
`timescale 1ns/1ps
module aclink_rx_deframer_tb;
  localparam int NS = 12;
  localparam int FB = 256;

  logic clk = 1'b0;
  logic rst, ac_sync, ac_sdin;
  logic            frame_valid, frame_err, codec_ready;
  logic [NS-1:0]   slot_valid;
  logic [15:0]     tag_slot;
  logic [NS*20-1:0] slot_data;
  logic [NS*18-1:0] pcm_data;

  int n_chk = 0, n_bad = 0;
  int fv_cnt = 0, fe_cnt = 0;

  always #10 clk = ~clk;

  aclink_rx_deframer u_dut (
    .ac_bclk(clk), .rst(rst), .ac_sync(ac_sync), .ac_sdin(ac_sdin),
    .frame_valid(frame_valid), .frame_err(frame_err), .codec_ready(codec_ready),
    .slot_valid(slot_valid), .tag_slot(tag_slot), .slot_data(slot_data),
    .pcm_data(pcm_data)
  );

  always @(posedge clk) begin
    if (frame_valid) fv_cnt <= fv_cnt + 1;
    if (frame_err)   fe_cnt <= fe_cnt + 1;
  end

  // {tag, seed, expected slot_valid}
  localparam logic [43:0] VEC [4] = '{
    {16'hF800, 16'h0011, 12'h00F},
    {16'h9800, 16'h0022, 12'h00C},
    {16'h0000, 16'h0033, 12'h000},
    {16'hFFF8, 16'h0044, 12'hFFF}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mk_frame(input logic [15:0] tag, input logic [15:0] seed);
    logic [255:0] f;
    f[255:240] = tag;
    for (int n = 1; n <= NS; n++) begin
      logic [31:0] v;
      v = (32'(seed) + 32'd1) * (32'(n) * 32'd7919) + 32'(n) * 32'h1B3 + 32'(seed) * 32'h9E37;
      f[239-(n-1)*20 -: 20] = v[19:0];
    end
    return f;
  endfunction

  task automatic send_frame(input logic [255:0] f, input int nbits);
    for (int b = 0; b < nbits; b++) begin
      @(posedge clk);
      ac_sync <= (b < 16);
      ac_sdin <= f[255-b];
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      ac_sync <= 1'b0;
      ac_sdin <= k[0] ^ k[2];
    end
  endtask

  task automatic check_outputs(input logic [255:0] f, input string tagname);
    chk({"R2 tag ", tagname}, 64'(tag_slot), 64'(f[255:240]));
    chk({"R6 ready ", tagname}, 64'(codec_ready), 64'(f[255]));
    for (int n = 1; n <= NS; n++) begin
      chk({"R3 slot ", tagname}, 64'(slot_data[(n-1)*20 +: 20]), 64'(f[239-(n-1)*20 -: 20]));
      chk({"R8 pcm ", tagname}, 64'(pcm_data[(n-1)*18 +: 18]), 64'(f[239-(n-1)*20 -: 18]));
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [255:0] fa, fb, fc, fd;
    int fv0, fe0;
    rst = 1'b1; ac_sync = 1'b1; ac_sdin = 1'b0;
    repeat (4) @(posedge clk);
    chk("R1 reset valid", 64'(frame_valid), 64'd0);
    chk("R1 reset tag", 64'(tag_slot), 64'd0);
    chk("R1 reset data", 64'(|slot_data), 64'd0);
    chk("R1 reset ready", 64'(codec_ready), 64'd0);
    chk("R1 reset err", 64'(frame_err), 64'd0);
    rst <= 1'b0;

    // sync high through reset: no frame without a real rising edge
    for (int b = 0; b < 300; b++) begin
      @(posedge clk);
      ac_sync <= 1'b1;
      ac_sdin <= b[1];
    end
    idle(8);
    chk("R1 no frame without edge", 64'(fv_cnt), 64'd0);

    // vector table
    for (int v = 0; v < 4; v++) begin
      logic [255:0] f;
      f = mk_frame(VEC[v][43:28], VEC[v][27:12]);
      fv0 = fv_cnt;
      send_frame(f, FB);
      @(posedge clk);
      chk("R4 strobe after last bit", 64'(frame_valid), 64'd1);
      ac_sync <= 1'b0;
      check_outputs(f, $sformatf("vec%0d", v));
      chk("R7 slot valid", 64'(slot_valid), 64'(VEC[v][11:0]));
      @(posedge clk);
      chk("R4 strobe one period", 64'(frame_valid), 64'd0);
      idle(6);
      chk("R4 one strobe per frame", 64'(fv_cnt - fv0), 64'd1);
    end

    // R5 / R10: bits without sync are ignored
    fv0 = fv_cnt;
    idle(300);
    chk("R10 no strobe without sync", 64'(fv_cnt - fv0), 64'd0);
    chk("R5 tag held", 64'(tag_slot), 64'hFFF8);
    chk("R5 valid held", 64'(slot_valid), 64'hFFF);

    // R9: truncated frame
    fa = mk_frame(16'hF800, 16'h0101);
    fb = mk_frame(16'h9800, 16'h0202);
    fv0 = fv_cnt; fe0 = fe_cnt;
    send_frame(fa, 100);
    send_frame(fb, FB);
    idle(4);
    chk("R9 error pulse", 64'(fe_cnt - fe0), 64'd1);
    chk("R9 partial frame dropped", 64'(fv_cnt - fv0), 64'd1);
    check_outputs(fb, "after_err");

    // R10: back-to-back frames, no error
    fc = mk_frame(16'h9800, 16'h0303);
    fd = mk_frame(16'hF800, 16'h0404);
    fv0 = fv_cnt; fe0 = fe_cnt;
    send_frame(fc, FB);
    send_frame(fd, FB);
    idle(4);
    chk("R10 back-to-back no error", 64'(fe_cnt - fe0), 64'd0);
    chk("R10 back-to-back strobes", 64'(fv_cnt - fv0), 64'd2);
    check_outputs(fd, "b2b");
    chk("R7 slot valid F800", 64'(slot_valid), 64'h00F);

    // R1: reset mid-operation clears outputs
    @(posedge clk); rst <= 1'b1;
    repeat (2) @(posedge clk);
    chk("R1 mid reset tag", 64'(tag_slot), 64'd0);
    chk("R1 mid reset valid vec", 64'(slot_valid), 64'd0);
    chk("R1 mid reset data", 64'(|pcm_data), 64'd0);
    rst <= 1'b0;
    idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule